// File: doc/BRIEF.md
# Header-Validated Configuration Loader

After reset this block fills a byte-wide configuration RAM without help from software. It first writes zero to every RAM address, then places a small built-in default image at address 0x4000. Next it reads a serial EEPROM image through a byte-fetch request/acknowledge handshake. The serial bus itself is not part of this block: an external agent returns one byte for each request.

The first four EEPROM bytes form a header. Two of them are magic bytes, and two give a big-endian resource length. When both magic bytes match, the rest of the EEPROM is copied over the defaults, starting at 0x4000. The block then reports the resource length, clamped to 384. When either magic byte differs, nothing more is read, the defaults stay in place and the length reads 19. That is the size of the default image, so the resource region that follows the defaults begins at 0x4013. A done flag closes the sequence and holds until the next reset.

Top module: `cfgld_loader`

## Requirements
- R1: After reset is released, the first RAM writes store 0x00 at every address from 0 to 2^RAM_AW-1, in ascending order, one write per clock cycle, before any other write.
- R2: Straight after the clear, the block writes the 19-byte default image to addresses 0x4000 to 0x4012 in ascending order. Default byte i has the value (29*i + 3) mod 256.
- R3: The first four EEPROM fetches request byte addresses 0, 1, 2 and 3 in that order. Once ee_req is high, it stays high and ee_addr stays stable until a cycle in which ee_ack is high. ee_data is taken in that acknowledge cycle.
- R4: hdr_valid is 1 exactly when EEPROM byte 0 equals 0x55 and byte 1 equals 0xBB.
- R5: For a valid header, rsrc_len equals byte 2 * 256 + byte 3 whenever that value is 384 or less. This includes exactly 384.
- R6: For a valid header whose length field is above 384, rsrc_len is 384.
- R7: For a valid header, EEPROM bytes 4 to 2^EE_AW-1 are fetched in ascending order. Byte a is written to RAM address 0x4000 + a - 4 with its fetched value, and no later write reaches any other address.
- R8: For an invalid header, no fetch follows byte 3 and no RAM write follows the default image. hdr_valid is 0 and rsrc_len is 19.
- R9: While reset is held, done, hdr_valid, ee_req and ram_we are 0 and rsrc_len is 0. Once loading ends, done rises and stays high until the next reset. While done is high, ee_req and ram_we remain 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; the load starts when it is released |
| ee_req | output | 1 | EEPROM byte fetch request |
| ee_addr | output | EE_AW | EEPROM byte address for the pending fetch |
| ee_ack | input | 1 | Fetch acknowledge; ee_data is valid in the same cycle |
| ee_data | input | 8 | Fetched EEPROM byte |
| ram_we | output | 1 | Configuration RAM write strobe |
| ram_addr | output | RAM_AW | Configuration RAM write address |
| ram_wdata | output | 8 | Configuration RAM write data |
| done | output | 1 | Load sequence finished |
| hdr_valid | output | 1 | Header magic matched |
| rsrc_len | output | LEN_W | Reported resource data length |

## Verification
A sequencer stuck in the wrong phase shows up on the first write that leaves the expected address order. That happens within one cycle for the clear and default phases, and within one fetch for the copy phase. The scoreboard compares every write against its expected address and data, so the write that goes wrong is the one reported. A wrong header decision is visible when done rises: hdr_valid and rsrc_len are wrong, and the count of fetches and writes is off by the whole payload. A premature or missing end shows up as a done flag that never rises, or as leftover expected writes.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

   typedef enum logic [2:0] {
      ST_CLEAR,
      ST_DEFLT,
      ST_HDR,
      ST_COPY,
      ST_DONE
   } ld_state_t;

   // built-in default image: byte i = 29*i + 3 (mod 256)
   function automatic logic [7:0] dflt_byte(input int unsigned i);
      return 8'((i * 29 + 3) & 255);
   endfunction

endpackage

// File: rtl/cfgld_fetch.sv
module cfgld_fetch #(
   parameter int AW = 13
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [AW-1:0] addr_in,
   output logic          ee_req,
   output logic [AW-1:0] ee_addr,
   input  logic          ee_ack,
   input  logic [7:0]    ee_data,
   output logic          got,
   output logic [7:0]    rbyte
);

   logic busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         ee_addr <= '0;
         got     <= 1'b0;
         rbyte   <= '0;
      end else begin
         got <= 1'b0;
         if (busy && ee_ack) begin
            busy  <= 1'b0;
            got   <= 1'b1;
            rbyte <= ee_data;
         end else if (go && !busy) begin
            busy    <= 1'b1;
            ee_addr <= addr_in;
         end
      end
   end

   assign ee_req = busy;

endmodule

// File: rtl/cfgld_hdr.sv
module cfgld_hdr #(
   parameter int         LEN_W   = 16,
   parameter int         LEN_CAP = 384,
   parameter int         DEF_LEN = 19,
   parameter logic [7:0] MAGIC0  = 8'h55,
   parameter logic [7:0] MAGIC1  = 8'hBB
) (
   input  logic [7:0]       b0,
   input  logic [7:0]       b1,
   input  logic [7:0]       b2,
   input  logic [7:0]       b3,
   output logic             ok,
   output logic [LEN_W-1:0] len
);

   localparam logic [LEN_W-1:0] CAP_V = LEN_W'(LEN_CAP);
   localparam logic [LEN_W-1:0] DEF_V = LEN_W'(DEF_LEN);

   logic [LEN_W-1:0] raw;

   always_comb begin
      raw = LEN_W'({b2, b3});
      ok  = (b0 == MAGIC0) && (b1 == MAGIC1);
      if (!ok)
         len = DEF_V;
      else if (raw > CAP_V)
         len = CAP_V;
      else
         len = raw;
   end

endmodule

// File: rtl/cfgld_loader.sv
module cfgld_loader #(
   parameter int         RAM_AW   = 16,
   parameter int         EE_AW    = 13,
   parameter int         IMG_BASE = 16'h4000,
   parameter int         DEF_LEN  = 19,
   parameter int         LEN_CAP  = 384,
   parameter int         LEN_W    = 16,
   parameter logic [7:0] MAGIC0   = 8'h55,
   parameter logic [7:0] MAGIC1   = 8'hBB
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              ee_req,
   output logic [EE_AW-1:0]  ee_addr,
   input  logic              ee_ack,
   input  logic [7:0]        ee_data,
   output logic              ram_we,
   output logic [RAM_AW-1:0] ram_addr,
   output logic [7:0]        ram_wdata,
   output logic              done,
   output logic              hdr_valid,
   output logic [LEN_W-1:0]  rsrc_len
);
   import cfgld_pkg::*;

   localparam int RAM_DEPTH = 2 ** RAM_AW;
   localparam int EE_SIZE   = 2 ** EE_AW;
   localparam int HDR_LEN   = 4;
   localparam logic [RAM_AW-1:0] BASE_A   = RAM_AW'(IMG_BASE);
   localparam logic [RAM_AW-1:0] CLR_LAST = RAM_AW'(RAM_DEPTH - 1);
   localparam logic [RAM_AW-1:0] DEF_LAST = RAM_AW'(DEF_LEN - 1);
   localparam logic [EE_AW-1:0]  HDR_LAST = EE_AW'(HDR_LEN - 1);
   localparam logic [EE_AW-1:0]  EE_LAST  = EE_AW'(EE_SIZE - 1);

   generate
      if (EE_AW < 3 || EE_AW >= RAM_AW)
         $error("cfgld_loader: EE_AW must be at least 3 and below RAM_AW");
      if (IMG_BASE + EE_SIZE - HDR_LEN > RAM_DEPTH || IMG_BASE + DEF_LEN > RAM_DEPTH)
         $error("cfgld_loader: image does not fit in the RAM");
      if (LEN_W < 16 || LEN_CAP >= 2 ** LEN_W || DEF_LEN < 1)
         $error("cfgld_loader: bad length parameters");
   endgenerate

   ld_state_t         st;
   logic [RAM_AW-1:0] cnt;
   logic [EE_AW-1:0]  idx;
   logic [7:0]        hb0, hb1, hb2;
   logic              inflight;
   logic              go, got;
   logic [7:0]        rbyte;
   logic              hok;
   logic [LEN_W-1:0]  hlen;

   assign go = ((st == ST_HDR) || (st == ST_COPY)) && !inflight;

   cfgld_fetch #(.AW(EE_AW)) u_fetch (
      .clk     (clk),
      .rst_n   (rst_n),
      .go      (go),
      .addr_in (idx),
      .ee_req  (ee_req),
      .ee_addr (ee_addr),
      .ee_ack  (ee_ack),
      .ee_data (ee_data),
      .got     (got),
      .rbyte   (rbyte)
   );

   cfgld_hdr #(
      .LEN_W   (LEN_W),
      .LEN_CAP (LEN_CAP),
      .DEF_LEN (DEF_LEN),
      .MAGIC0  (MAGIC0),
      .MAGIC1  (MAGIC1)
   ) u_hdr (
      .b0  (hb0),
      .b1  (hb1),
      .b2  (hb2),
      .b3  (rbyte),
      .ok  (hok),
      .len (hlen)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= ST_CLEAR;
         cnt       <= '0;
         idx       <= '0;
         hb0       <= '0;
         hb1       <= '0;
         hb2       <= '0;
         inflight  <= 1'b0;
         ram_we    <= 1'b0;
         ram_addr  <= '0;
         ram_wdata <= '0;
         done      <= 1'b0;
         hdr_valid <= 1'b0;
         rsrc_len  <= '0;
      end else begin
         ram_we <= 1'b0;
         if (go)
            inflight <= 1'b1;
         if (got)
            inflight <= 1'b0;
         case (st)
            ST_CLEAR: begin
               ram_we    <= 1'b1;
               ram_addr  <= cnt;
               ram_wdata <= 8'h00;
               if (cnt == CLR_LAST) begin
                  cnt <= '0;
                  st  <= ST_DEFLT;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_DEFLT: begin
               ram_we    <= 1'b1;
               ram_addr  <= BASE_A + cnt;
               ram_wdata <= dflt_byte(32'(cnt));
               if (cnt == DEF_LAST) begin
                  idx <= '0;
                  st  <= ST_HDR;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_HDR: begin
               if (got) begin
                  case (idx[1:0])
                     2'd0:    hb0 <= rbyte;
                     2'd1:    hb1 <= rbyte;
                     2'd2:    hb2 <= rbyte;
                     default: ;
                  endcase
                  idx <= idx + 1'b1;
                  if (idx == HDR_LAST) begin
                     hdr_valid <= hok;
                     rsrc_len  <= hlen;
                     st        <= hok ? ST_COPY : ST_DONE;
                  end
               end
            end
            ST_COPY: begin
               if (got) begin
                  ram_we    <= 1'b1;
                  ram_addr  <= BASE_A + RAM_AW'(idx) - RAM_AW'(HDR_LEN);
                  ram_wdata <= rbyte;
                  if (idx == EE_LAST)
                     st <= ST_DONE;
                  else
                     idx <= idx + 1'b1;
               end
            end
            default: done <= 1'b1;
         endcase
      end
   end

endmodule

// File: rtl/cfgld_loader_chk.sv
module cfgld_loader_chk #(
   parameter int RAM_AW  = 16,
   parameter int EE_AW   = 13,
   parameter int DEF_LEN = 19,
   parameter int LEN_CAP = 384,
   parameter int LEN_W   = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ee_req,
   input logic [EE_AW-1:0]  ee_addr,
   input logic              ee_ack,
   input logic              ram_we,
   input logic              done,
   input logic              hdr_valid,
   input logic [LEN_W-1:0]  rsrc_len
);

   // R3: a pending fetch holds its request and address until acknowledged
   a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (ee_req && !ee_ack) |=> (ee_req && $stable(ee_addr)));

   // R9: no fetch and no write once done
   a_r9_quiet_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!ee_req && !ram_we));

   // R9: done holds until reset
   a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done);

   // R6: reported length never exceeds the cap
   a_r6_len_cap: assert property (@(posedge clk) disable iff (!rst_n)
      rsrc_len <= LEN_W'(LEN_CAP));

   // R8: a rejected header reports the default length
   a_r8_invalid_len: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !hdr_valid) |-> (rsrc_len == LEN_W'(DEF_LEN)));

endmodule

bind cfgld_loader cfgld_loader_chk #(
   .RAM_AW  (RAM_AW),
   .EE_AW   (EE_AW),
   .DEF_LEN (DEF_LEN),
   .LEN_CAP (LEN_CAP),
   .LEN_W   (LEN_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ee_req    (ee_req),
   .ee_addr   (ee_addr),
   .ee_ack    (ee_ack),
   .ram_we    (ram_we),
   .done      (done),
   .hdr_valid (hdr_valid),
   .rsrc_len  (rsrc_len)
);

// File: tb/cfgld_loader_bench.sv
module cfgld_loader_bench;

   localparam int RAM_AW  = 15;
   localparam int EE_AW   = 8;
   localparam int EE_SIZE = 2 ** EE_AW;
   localparam int BASE    = 16'h4000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              ee_req;
   logic [EE_AW-1:0]  ee_addr;
   logic              ee_ack = 1'b0;
   logic [7:0]        ee_data = 8'h00;
   logic              ram_we;
   logic [RAM_AW-1:0] ram_addr;
   logic [7:0]        ram_wdata;
   logic              done;
   logic              hdr_valid;
   logic [15:0]       rsrc_len;

   always #4 clk = ~clk;

   cfgld_loader #(.RAM_AW(RAM_AW), .EE_AW(EE_AW)) u_cfgld_loader (
      .clk       (clk),
      .rst_n     (rst_n),
      .ee_req    (ee_req),
      .ee_addr   (ee_addr),
      .ee_ack    (ee_ack),
      .ee_data   (ee_data),
      .ram_we    (ram_we),
      .ram_addr  (ram_addr),
      .ram_wdata (ram_wdata),
      .done      (done),
      .hdr_valid (hdr_valid),
      .rsrc_len  (rsrc_len)
   );

   int errors = 0;
   int checks = 0;
   bit finished = 0;
   logic [7:0] ee_mem [EE_SIZE];
   logic [RAM_AW+7:0] exp_q [$];
   string tag_q [$];
   int ack_gap = 0;
   int gap_cnt = 0;
   int rd_cnt = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // driver: pushes the expected write stream for one load
   task automatic push_expected(input bit valid);
      for (int a = 0; a < 2 ** RAM_AW; a++) begin
         exp_q.push_back({RAM_AW'(a), 8'h00});
         tag_q.push_back("R1 clear write");
      end
      for (int i = 0; i < 19; i++) begin
         exp_q.push_back({RAM_AW'(BASE + i), 8'((i * 29 + 3) & 255)});
         tag_q.push_back("R2 default write");
      end
      if (valid)
         for (int a = 4; a < EE_SIZE; a++) begin
            exp_q.push_back({RAM_AW'(BASE + a - 4), ee_mem[a]});
            tag_q.push_back("R7 payload write");
         end
   endtask

   // EEPROM responder, also checks fetch order (R3, R7)
   initial begin
      forever begin
         @(negedge clk);
         if (ee_ack) begin
            ee_ack = 1'b0;
         end else if (rst_n && ee_req) begin
            if (gap_cnt < ack_gap) begin
               gap_cnt++;
            end else begin
               gap_cnt = 0;
               chk(int'(ee_addr) == rd_cnt, "R3 fetch address order", int'(ee_addr), rd_cnt);
               rd_cnt++;
               ee_data = ee_mem[ee_addr];
               ee_ack  = 1'b1;
            end
         end
      end
   end

   // monitor: pops expected writes and compares
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && ram_we) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R8 unexpected RAM write", int'({ram_addr, ram_wdata}), 0);
            end else begin
               logic [RAM_AW+7:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               chk({ram_addr, ram_wdata} == e, t, int'({ram_addr, ram_wdata}), int'(e));
            end
         end
      end
   end

   task automatic run_load(input int gap, input bit valid, input int exp_len);
      int n;
      int busy;
      rst_n   = 1'b0;
      ack_gap = gap;
      gap_cnt = 0;
      rd_cnt  = 0;
      exp_q.delete();
      tag_q.delete();
      repeat (3) @(negedge clk);
      chk(!done && !hdr_valid && !ee_req && !ram_we && rsrc_len == 0, "R9 reset state",
          int'({done, hdr_valid, ee_req, ram_we}), 0);
      push_expected(valid);
      rst_n = 1'b1;
      n = 0;
      while (!done && n < 60000) begin
         @(negedge clk);
         n++;
      end
      chk(done, "R9 done rises", int'(done), 1);
      chk(hdr_valid == valid, "R4 header verdict", int'(hdr_valid), int'(valid));
      chk(int'(rsrc_len) == exp_len, valid ? "R5 R6 resource length" : "R8 default length",
          int'(rsrc_len), exp_len);
      chk(exp_q.size() == 0, "R7 all expected writes seen", exp_q.size(), 0);
      chk(rd_cnt == (valid ? EE_SIZE : 4), valid ? "R7 fetch count" : "R8 fetch count",
          rd_cnt, valid ? EE_SIZE : 4);
      busy = 0;
      repeat (20) begin
         @(negedge clk);
         if (ee_req || ram_we || !done) busy++;
      end
      chk(busy == 0, "R9 quiet after done", busy, 0);
   endtask

   task automatic fill_ee(input logic [7:0] m0, input logic [7:0] m1,
                          input logic [15:0] len, input int seed);
      for (int a = 0; a < EE_SIZE; a++) ee_mem[a] = 8'((a * 7 + seed) & 255);
      ee_mem[0] = m0;
      ee_mem[1] = m1;
      ee_mem[2] = len[15:8];
      ee_mem[3] = len[7:0];
   endtask

   initial begin
      repeat (195000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      fill_ee(8'h55, 8'hBB, 16'd100, 5);
      run_load(0, 1'b1, 100);                // R5
      fill_ee(8'h55, 8'hBB, 16'h0200, 91);
      run_load(2, 1'b1, 384);                // R6
      fill_ee(8'h55, 8'hBB, 16'h0180, 33);
      run_load(1, 1'b1, 384);                // R5 boundary
      fill_ee(8'h55, 8'hBA, 16'd50, 17);
      run_load(0, 1'b0, 19);                 // R8, R4
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule